// File: doc/BRIEF.md
# In-Band XON/XOFF Flow Control Engine

This block sits next to a serial port core and handles software flow control. On the receive side it checks every received character against four programmable characters. The characters form two pairs, and each pair has one resume character and one pause character. A pause match stops the transmitter from starting new data characters. A resume match lets it start them again. A character that the core is already shifting out is never cut short, because the block only gates the start of the next character.

On the transmit side the block compares the receive FIFO fill level with an upper and a lower threshold. When a threshold is crossed, it asks the core to insert a pause or resume character into the outgoing stream. An inserted control character goes ahead of the next data character.

A separate special-character detector watches for the second pause character. When it sees one, it passes the byte to the receive holding register and latches an interrupt, which stays set until software reads the interrupt status. All of these functions need the enhanced-mode bit to be set, and the two flow-control directions are also switched off while the core runs with 9-bit characters.

Top module: `xflow_engine`

## Requirements
- R1: While `cfgEnhanced` is 0, the block pauses nothing, issues no insertion request and raises no special interrupt, whatever the other mode bits say. Every received byte is stored (`rxStore` is 1).
- R2: The receive mode uses these encodings. 2'b00 turns receive flow control off. 2'b01 uses `xon2`/`xoff2` as the active pair. 2'b10 uses `xon1`/`xoff1`. A character from the inactive pair is stored and has no flow effect.
- R3: Receive mode 2'b11 accepts both `xoff1` and `xoff2` as pause and both `xon1` and `xon2` as resume, but only while the transmit mode is 2'b01 or 2'b10. With any other transmit mode, receive mode 2'b11 acts as disabled.
- R4: After an active pause character is received, `dataEnable` reads 0 in the cycle after `rxValid`. A later active resume character sets it back to 1. A character consumed for flow control is not stored (`rxStore` stays 0). If one byte matches both pause and resume, pause wins. `dataEnable` only gates the start of the next character.
- R5: The transmit mode uses these encodings. 2'b01 inserts `xon2`/`xoff2`. 2'b10 inserts `xon1`/`xoff1`. 2'b00 and 2'b11 never insert.
- R6: When `fifoLevel > hiThresh`, the block raises `ctrlReq` with the pause character on `ctrlChar` one cycle later. The request holds until `ctrlTaken`. After a pause character has been taken, `fifoLevel < loThresh` requests the resume character. No second pause request is made until a resume character has been taken.
- R7: While `ctrlReq` is 1, `dataEnable` is 0, so an inserted character goes ahead of pending data.
- R8: With `cfgEnhanced` and `cfgSpecialEn` set, a received byte equal to `xoff2` is stored (`rxStore` 1, `rxByte` = byte) even when it also acts as a pause. If `cfgIntEn` is 1, it also sets `specialInt` in the next cycle.
- R9: `specialInt` stays 1 until `intRead` is pulsed. If a new detection and `intRead` fall in the same cycle, the detection wins.
- R10: While `cfgNineBit` is 1, receive and transmit flow control are both inactive: no pause, no request, and all bytes are stored.
- R11: After reset, `dataEnable` is 1 and `ctrlReq`, `specialInt` and `rxStore` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cfgEnhanced | input | 1 | Enhanced-mode enable; gates all functions |
| cfgRxMode | input | 2 | Receive flow mode |
| cfgTxMode | input | 2 | Transmit flow mode |
| cfgSpecialEn | input | 1 | Special-character detection enable |
| cfgIntEn | input | 1 | Special interrupt enable |
| cfgNineBit | input | 1 | Core runs with 9-bit characters |
| xon1 | input | CHAR_W | First resume character |
| xon2 | input | CHAR_W | Second resume character |
| xoff1 | input | CHAR_W | First pause character |
| xoff2 | input | CHAR_W | Second pause character, also the special character |
| hiThresh | input | LVL_W | Upper fill threshold |
| loThresh | input | LVL_W | Lower fill threshold |
| fifoLevel | input | LVL_W | Receive FIFO fill level |
| rxValid | input | 1 | Received byte strobe |
| rxData | input | CHAR_W | Received byte |
| ctrlTaken | input | 1 | Core has started sending `ctrlChar` |
| intRead | input | 1 | Software read of interrupt status |
| dataEnable | output | 1 | Core may start the next data character |
| ctrlReq | output | 1 | Insertion of `ctrlChar` requested |
| ctrlChar | output | CHAR_W | Control character to insert |
| rxStore | output | 1 | Write `rxByte` to the receive holding register |
| rxByte | output | CHAR_W | Byte to store |
| specialInt | output | 1 | Pending special-character interrupt |

## Verification
Two functions can act on the same received byte. With receive mode 2'b01 and special detection on, one `xoff2` byte both pauses the transmitter and triggers the special path. The bench sends that byte and expects three results together in the next cycle: `dataEnable` low, `rxStore` high with the byte on `rxByte`, and `specialInt` set. A second collision is a detection that lands in the same cycle as `intRead`. The bench drives both on one edge and requires `specialInt` to stay set, then clears it with a separate read.

// File: rtl/xflow_pkg.sv
package xflow_pkg;

  localparam logic [1:0] MODE_OFF  = 2'b00;
  localparam logic [1:0] MODE_SET2 = 2'b01;
  localparam logic [1:0] MODE_SET1 = 2'b10;
  localparam logic [1:0] MODE_BOTH = 2'b11;

  // datapath -> control: comparator results and held state
  typedef struct packed {
    logic hitXon1;
    logic hitXon2;
    logic hitXoff1;
    logic hitXoff2;
    logic above;
    logic below;
    logic pending;
    logic kindXoff;
    logic xoffSent;
  } xfStatus_t;

  // control -> datapath: one-cycle strobes
  typedef struct packed {
    logic rxOff;
    logic pause;
    logic resume;
    logic store;
    logic setInt;
    logic reqXoff;
    logic reqXon;
    logic take;
    logic flush;
    logic useSet2;
  } xfStrobe_t;

endpackage

// File: rtl/xflow_ctrl.sv
module xflow_ctrl
  import xflow_pkg::*;
(
  input  logic      cfgEnhanced,
  input  logic [1:0] cfgRxMode,
  input  logic [1:0] cfgTxMode,
  input  logic      cfgSpecialEn,
  input  logic      cfgIntEn,
  input  logic      cfgNineBit,
  input  logic      rxValid,
  input  logic      ctrlTaken,
  input  xfStatus_t st,
  output xfStrobe_t sb
);

  logic txActive;
  logic rxActive;
  logic xoffHit;
  logic xonHit;
  logic special;

  always_comb begin
    txActive = cfgEnhanced && !cfgNineBit &&
               (cfgTxMode == MODE_SET1 || cfgTxMode == MODE_SET2);
    rxActive = cfgEnhanced && !cfgNineBit && (cfgRxMode != MODE_OFF) &&
               (cfgRxMode != MODE_BOTH || txActive);
    xoffHit = 1'b0;
    xonHit  = 1'b0;
    if (rxActive) begin
      unique case (cfgRxMode)
        MODE_SET2: begin xoffHit = st.hitXoff2; xonHit = st.hitXon2; end
        MODE_SET1: begin xoffHit = st.hitXoff1; xonHit = st.hitXon1; end
        MODE_BOTH: begin
          xoffHit = st.hitXoff1 || st.hitXoff2;
          xonHit  = st.hitXon1 || st.hitXon2;
        end
        default: begin xoffHit = 1'b0; xonHit = 1'b0; end
      endcase
    end
    special = cfgEnhanced && cfgSpecialEn && rxValid && st.hitXoff2;

    sb.rxOff   = !rxActive;
    sb.pause   = rxValid && xoffHit;
    sb.resume  = rxValid && xonHit && !xoffHit;
    sb.store   = rxValid && (!(xoffHit || xonHit) || special);
    sb.setInt  = special && cfgIntEn;
    sb.flush   = !txActive;
    sb.reqXoff = txActive && !st.pending && !st.xoffSent && st.above;
    sb.reqXon  = txActive && !st.pending && st.xoffSent && st.below;
    sb.take    = st.pending && ctrlTaken;
    sb.useSet2 = (cfgTxMode == MODE_SET2);
  end

endmodule

// File: rtl/xflow_datapath.sv
module xflow_datapath
  import xflow_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAR_W-1:0] xon1,
  input  logic [CHAR_W-1:0] xon2,
  input  logic [CHAR_W-1:0] xoff1,
  input  logic [CHAR_W-1:0] xoff2,
  input  logic [LVL_W-1:0]  hiThresh,
  input  logic [LVL_W-1:0]  loThresh,
  input  logic [LVL_W-1:0]  fifoLevel,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              intRead,
  input  xfStrobe_t         sb,
  output xfStatus_t         st,
  output logic              dataEnable,
  output logic              ctrlReq,
  output logic [CHAR_W-1:0] ctrlChar,
  output logic              rxStore,
  output logic [CHAR_W-1:0] rxByte,
  output logic              specialInt
);

  localparam int NUM_CHARS = 4;

  logic [CHAR_W-1:0] charTab [NUM_CHARS];
  logic [NUM_CHARS-1:0] hit;
  logic paused;
  logic pending;
  logic kindXoff;
  logic xoffSent;
  logic intPend;

  assign charTab[0] = xon1;
  assign charTab[1] = xon2;
  assign charTab[2] = xoff1;
  assign charTab[3] = xoff2;

  for (genvar i = 0; i < NUM_CHARS; i++) begin : g_cmp
    assign hit[i] = (rxData == charTab[i]);
  end

  always_comb begin
    st.hitXon1  = hit[0];
    st.hitXon2  = hit[1];
    st.hitXoff1 = hit[2];
    st.hitXoff2 = hit[3];
    st.above    = fifoLevel > hiThresh;
    st.below    = fifoLevel < loThresh;
    st.pending  = pending;
    st.kindXoff = kindXoff;
    st.xoffSent = xoffSent;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paused   <= 1'b0;
      pending  <= 1'b0;
      kindXoff <= 1'b0;
      xoffSent <= 1'b0;
      intPend  <= 1'b0;
      rxStore  <= 1'b0;
      rxByte   <= '0;
    end else begin
      if (sb.rxOff)       paused <= 1'b0;
      else if (sb.pause)  paused <= 1'b1;
      else if (sb.resume) paused <= 1'b0;

      if (sb.flush) begin
        pending  <= 1'b0;
        xoffSent <= 1'b0;
      end else if (sb.take) begin
        pending  <= 1'b0;
        xoffSent <= kindXoff;
      end else if (sb.reqXoff) begin
        pending  <= 1'b1;
        kindXoff <= 1'b1;
      end else if (sb.reqXon) begin
        pending  <= 1'b1;
        kindXoff <= 1'b0;
      end

      if (sb.setInt)     intPend <= 1'b1;
      else if (intRead)  intPend <= 1'b0;

      rxStore <= sb.store;
      if (rxValid) rxByte <= rxData;
    end
  end

  always_comb begin
    dataEnable = !paused && !pending;
    ctrlReq    = pending;
    specialInt = intPend;
    if (kindXoff) ctrlChar = sb.useSet2 ? xoff2 : xoff1;
    else          ctrlChar = sb.useSet2 ? xon2 : xon1;
  end

endmodule

// File: rtl/xflow_engine.sv
module xflow_engine
  import xflow_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnhanced,
  input  logic [1:0]        cfgRxMode,
  input  logic [1:0]        cfgTxMode,
  input  logic              cfgSpecialEn,
  input  logic              cfgIntEn,
  input  logic              cfgNineBit,
  input  logic [CHAR_W-1:0] xon1,
  input  logic [CHAR_W-1:0] xon2,
  input  logic [CHAR_W-1:0] xoff1,
  input  logic [CHAR_W-1:0] xoff2,
  input  logic [LVL_W-1:0]  hiThresh,
  input  logic [LVL_W-1:0]  loThresh,
  input  logic [LVL_W-1:0]  fifoLevel,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              ctrlTaken,
  input  logic              intRead,
  output logic              dataEnable,
  output logic              ctrlReq,
  output logic [CHAR_W-1:0] ctrlChar,
  output logic              rxStore,
  output logic [CHAR_W-1:0] rxByte,
  output logic              specialInt
);

  xfStatus_t st;
  xfStrobe_t sb;

  xflow_ctrl u_ctrl (
    .cfgEnhanced (cfgEnhanced),
    .cfgRxMode   (cfgRxMode),
    .cfgTxMode   (cfgTxMode),
    .cfgSpecialEn(cfgSpecialEn),
    .cfgIntEn    (cfgIntEn),
    .cfgNineBit  (cfgNineBit),
    .rxValid     (rxValid),
    .ctrlTaken   (ctrlTaken),
    .st          (st),
    .sb          (sb)
  );

  xflow_datapath #(.CHAR_W(CHAR_W), .LVL_W(LVL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .xon1      (xon1),
    .xon2      (xon2),
    .xoff1     (xoff1),
    .xoff2     (xoff2),
    .hiThresh  (hiThresh),
    .loThresh  (loThresh),
    .fifoLevel (fifoLevel),
    .rxValid   (rxValid),
    .rxData    (rxData),
    .intRead   (intRead),
    .sb        (sb),
    .st        (st),
    .dataEnable(dataEnable),
    .ctrlReq   (ctrlReq),
    .ctrlChar  (ctrlChar),
    .rxStore   (rxStore),
    .rxByte    (rxByte),
    .specialInt(specialInt)
  );

endmodule

// File: rtl/xflow_engine_chk.sv
module xflow_engine_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgEnhanced,
  input logic [1:0]        cfgTxMode,
  input logic              cfgSpecialEn,
  input logic              cfgIntEn,
  input logic              cfgNineBit,
  input logic [CHAR_W-1:0] xoff2,
  input logic              rxValid,
  input logic [CHAR_W-1:0] rxData,
  input logic              ctrlTaken,
  input logic              intRead,
  input logic              dataEnable,
  input logic              ctrlReq,
  input logic              specialInt
);

  logic txOn;
  assign txOn = cfgEnhanced && !cfgNineBit &&
                (cfgTxMode == 2'b01 || cfgTxMode == 2'b10);

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnhanced |=> (dataEnable && !ctrlReq)); // R1

  AST_PAUSE_FROM_RX: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dataEnable) && !ctrlReq) |-> $past(rxValid)); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReq && !ctrlTaken && txOn) |=> ctrlReq); // R6

  AST_REQ_BLOCKS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlReq) |-> !dataEnable); // R7

  AST_INT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(specialInt) |-> $past(rxValid && rxData == xoff2 && cfgEnhanced
                                && cfgSpecialEn && cfgIntEn)); // R8

  AST_INT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (specialInt && !intRead) |=> specialInt); // R9

  AST_NINE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    cfgNineBit |=> !ctrlReq); // R10

endmodule

bind xflow_engine xflow_engine_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgEnhanced (cfgEnhanced),
  .cfgTxMode   (cfgTxMode),
  .cfgSpecialEn(cfgSpecialEn),
  .cfgIntEn    (cfgIntEn),
  .cfgNineBit  (cfgNineBit),
  .xoff2       (xoff2),
  .rxValid     (rxValid),
  .rxData      (rxData),
  .ctrlTaken   (ctrlTaken),
  .intRead     (intRead),
  .dataEnable  (dataEnable),
  .ctrlReq     (ctrlReq),
  .specialInt  (specialInt)
);

// File: tb/xflow_engine_tb.sv
module xflow_engine_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgEnhanced = 1'b0;
  logic [1:0] cfgRxMode = 2'b00;
  logic [1:0] cfgTxMode = 2'b00;
  logic       cfgSpecialEn = 1'b0;
  logic       cfgIntEn = 1'b0;
  logic       cfgNineBit = 1'b0;
  logic [7:0] xon1 = 8'h11, xon2 = 8'hA1, xoff1 = 8'h13, xoff2 = 8'hA3;
  logic [7:0] hiThresh = 8'd12, loThresh = 8'd4, fifoLevel = 8'd8;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic       ctrlTaken = 1'b0;
  logic       intRead = 1'b0;
  logic       dataEnable, ctrlReq, rxStore, specialInt;
  logic [7:0] ctrlChar, rxByte;

  int nChecks = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  xflow_engine u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one-cycle byte strobe; returns just after the following negedge
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxData = b;
    rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
    #1;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic take();
    @(negedge clk);
    ctrlTaken = 1'b1;
    @(negedge clk);
    ctrlTaken = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R11 dataEnable", dataEnable, 1);
    chk("R11 ctrlReq", ctrlReq, 0);
    chk("R11 specialInt", specialInt, 0);
    chk("R11 rxStore", rxStore, 0);
  endtask

  task automatic t_disabled();
    cfgEnhanced = 0; cfgRxMode = 2'b10; cfgTxMode = 2'b10; cfgSpecialEn = 1; cfgIntEn = 1;
    sendByte(xoff1);
    chk("R1 no pause", dataEnable, 1);
    chk("R1 stored", rxStore, 1);
    sendByte(xoff2);
    chk("R1 no special int", specialInt, 0);
    fifoLevel = 8'd13;
    waitCyc(3);
    chk("R1 no request", ctrlReq, 0);
    fifoLevel = 8'd8;
    cfgSpecialEn = 0; cfgIntEn = 0;
    waitCyc(1);
  endtask

  task automatic t_rx10();
    cfgEnhanced = 1; cfgRxMode = 2'b10; cfgTxMode = 2'b10;
    sendByte(xoff2);
    chk("R2 inactive pair no pause", dataEnable, 1);
    chk("R2 inactive pair stored", rxStore, 1);
    sendByte(xoff1);
    chk("R4 pause", dataEnable, 0);
    chk("R4 xoff consumed", rxStore, 0);
    sendByte(8'h41);
    chk("R4 data byte stored", rxStore, 1);
    chk("R4 data byte value", rxByte, 8'h41);
    chk("R4 still paused", dataEnable, 0);
    sendByte(xon1);
    chk("R4 resume", dataEnable, 1);
    chk("R4 xon consumed", rxStore, 0);
  endtask

  task automatic t_rx01();
    cfgRxMode = 2'b01; cfgTxMode = 2'b01;
    sendByte(xoff1);
    chk("R2 mode01 ignores xoff1", dataEnable, 1);
    sendByte(xoff2);
    chk("R2 mode01 xoff2 pauses", dataEnable, 0);
    sendByte(xon1);
    chk("R2 mode01 ignores xon1", dataEnable, 0);
    sendByte(xon2);
    chk("R2 mode01 xon2 resumes", dataEnable, 1);
    cfgRxMode = 2'b00;
    sendByte(xoff2);
    chk("R2 mode00 no pause", dataEnable, 1);
    chk("R2 mode00 stored", rxStore, 1);
  endtask

  task automatic t_rx11();
    cfgRxMode = 2'b11; cfgTxMode = 2'b10;
    sendByte(xoff2);
    chk("R3 both xoff2", dataEnable, 0);
    sendByte(xon1);
    chk("R3 both xon1", dataEnable, 1);
    sendByte(xoff1);
    chk("R3 both xoff1", dataEnable, 0);
    sendByte(xon2);
    chk("R3 both xon2", dataEnable, 1);
    cfgTxMode = 2'b00;
    sendByte(xoff1);
    chk("R3 invalid with tx off", dataEnable, 1);
    chk("R3 invalid stored", rxStore, 1);
    cfgRxMode = 2'b00;
  endtask

  task automatic t_tx();
    cfgTxMode = 2'b10;
    waitCyc(1);
    chk("R6 idle no request", ctrlReq, 0);
    @(negedge clk); fifoLevel = 8'd13;
    @(negedge clk); #1;
    chk("R6 xoff request", ctrlReq, 1);
    chk("R5 mode10 xoff1", ctrlChar, xoff1);
    chk("R7 data blocked", dataEnable, 0);
    waitCyc(3);
    chk("R6 request held", ctrlReq, 1);
    take();
    chk("R6 cleared on take", ctrlReq, 0);
    chk("R7 data released", dataEnable, 1);
    waitCyc(4);
    chk("R6 no repeat xoff", ctrlReq, 0);
    @(negedge clk); fifoLevel = 8'd3;
    @(negedge clk); #1;
    chk("R6 xon request", ctrlReq, 1);
    chk("R5 mode10 xon1", ctrlChar, xon1);
    take();
    cfgTxMode = 2'b01;
    @(negedge clk); fifoLevel = 8'd13;
    @(negedge clk); #1;
    chk("R5 mode01 xoff2", ctrlChar, xoff2);
    take();
    @(negedge clk); fifoLevel = 8'd3;
    @(negedge clk); #1;
    chk("R5 mode01 xon2", ctrlChar, xon2);
    take();
    cfgTxMode = 2'b11;
    fifoLevel = 8'd13;
    waitCyc(3);
    chk("R5 mode11 reserved", ctrlReq, 0);
    cfgTxMode = 2'b00;
    waitCyc(2);
    chk("R5 mode00 off", ctrlReq, 0);
    fifoLevel = 8'd8;
  endtask

  task automatic t_nine();
    cfgNineBit = 1; cfgRxMode = 2'b10; cfgTxMode = 2'b10; fifoLevel = 8'd13;
    waitCyc(3);
    chk("R10 no request", ctrlReq, 0);
    sendByte(xoff1);
    chk("R10 no pause", dataEnable, 1);
    chk("R10 stored", rxStore, 1);
    fifoLevel = 8'd8; cfgNineBit = 0; cfgRxMode = 2'b00; cfgTxMode = 2'b00;
    waitCyc(1);
  endtask

  task automatic t_special();
    cfgRxMode = 2'b01; cfgTxMode = 2'b01; cfgSpecialEn = 1; cfgIntEn = 1;
    sendByte(xoff2);
    chk("R8 pause with special", dataEnable, 0);
    chk("R8 special stored", rxStore, 1);
    chk("R8 special byte", rxByte, xoff2);
    chk("R8 int raised", specialInt, 1);
    waitCyc(3);
    chk("R9 int held", specialInt, 1);
    @(negedge clk); intRead = 1;
    @(negedge clk); intRead = 0; #1;
    chk("R9 int cleared", specialInt, 0);
    cfgIntEn = 0;
    sendByte(xoff2);
    chk("R8 no int when disabled", specialInt, 0);
    chk("R8 stored without int", rxStore, 1);
    cfgIntEn = 1;
    @(negedge clk); rxData = xoff2; rxValid = 1; intRead = 1;
    @(negedge clk); rxValid = 0; intRead = 0; #1;
    chk("R9 set wins over read", specialInt, 1);
    @(negedge clk); intRead = 1;
    @(negedge clk); intRead = 0; #1;
    chk("R9 cleared after read", specialInt, 0);
    sendByte(xon2);
    chk("R4 resume after special", dataEnable, 1);
  endtask

  initial begin
    #(20 * 100000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    waitCyc(3);
    @(negedge clk); rstN = 1'b1; #1;
    t_reset();
    t_disabled();
    t_rx10();
    t_rx01();
    t_rx11();
    t_tx();
    t_nine();
    t_special();
    waitCyc(2);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule